// File: doc/BRIEF.md
# HDLC Frame Receiver

This block recovers HDLC frames from a serial payload stream. One bit is taken per clock cycle in which `bit_en` is high, so the block can sit behind any framer that delivers payload bits with gaps. The receiver hunts for the 0x7E flag, deletes the zeros that the sender inserted after runs of five ones, and detects aborts. It packs the remaining bits into octets, least significant bit first, and checks the frame check sequence at the closing flag.

Recovered payload octets leave on a byte-wide port that carries a valid strobe and start and end markers. The octet that carries the end marker also carries a two-bit frame status. The FCS width is chosen per frame by `fcs32_sel`. A short delay line holds back the last two or four octets, so the FCS itself is never presented as data. Frames that are too short to hold an FCS, and streams made only of flags, produce nothing at the output.

Top module: `hdlc_rx`

## Requirements
- R1: After reset, `rx_valid`, `rx_sof` and `rx_eof` are low, and no octet appears before a frame has been received.
- R2: A stream of flags (bit sequence 0,1,1,1,1,1,1,0 in arrival order) produces no output octet.
- R3: A 0 that follows five consecutive 1s is discarded. Payload octets are assembled with the first received bit as bit 0, and payloads containing 0xFF or 0x7E are recovered exactly.
- R4: With `fcs32_sel`=0, all octets of a frame except the trailing two are delivered in order. The first carries `rx_sof`, the last carries `rx_eof`, and `rx_status`=00 (good) is given when the CRC register matches the residue 0xF0B8. That register is preset to all ones and shifts LSB first with reflected polynomial 0x8408 over payload and FCS.
- R5: With `fcs32_sel`=1, the trailing four octets are withheld, and good status requires a residue of 0xDEBB20E3 (preset all ones, reflected polynomial 0xEDB88320).
- R6: A frame whose residue does not match ends with `rx_status`=01 on its `rx_eof` octet.
- R7: Seven consecutive 1s abort the frame. If octets were already delivered, the held-back last payload octet is issued with `rx_eof` and `rx_status`=10. All bits then up to the next flag are ignored.
- R8: A frame with fewer whole octets than the FCS length plus one produces no output.
- R9: If a closing flag arrives while a partial octet is pending, a frame long enough to have delivered octets ends with `rx_status`=10.
- R10: Flags sent back to back, and flags that share a single 0 between them, each act as a frame delimiter.
- R11: `bit_in` is ignored in cycles where `bit_en` is low.
- R12: `rx_sof` and `rx_eof` are asserted only with `rx_valid`. A frame with one payload octet yields a single octet carrying both markers, and `rx_status` is 00 on every octet without `rx_eof`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Serial payload bit |
| fcs32_sel | input | 1 | 1 selects the 32-bit FCS, 0 selects the 16-bit FCS |
| rx_valid | output | 1 | An octet is presented this cycle |
| rx_data | output | 8 | Recovered payload octet |
| rx_sof | output | 1 | First octet of a frame |
| rx_eof | output | 1 | Last octet of a frame; `rx_status` is valid |
| rx_status | output | 2 | 00 good, 01 FCS error, 10 aborted or not octet aligned |

## Verification
The assertions take for granted that `bit_in` is only meaningful when `bit_en` is high. They also assume that `fcs32_sel` changes only in the idle time after a closing flag and before the next payload bit. The stimulus keeps to this: it moves `fcs32_sel` only after a flag, once the pipeline has drained with `bit_en` low. During disabled cycles it drives random garbage on `bit_in`. Payloads are zero-stuffed by the bench, so that only flags and deliberate aborts form runs of six or more ones.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    // run lengths of consecutive ones that carry meaning on the line
    localparam int STUFF_RUN = 5;
    localparam int FLAG_RUN  = 6;
    localparam int ABORT_RUN = 7;
    localparam int ONES_W    = $clog2(ABORT_RUN + 1);
    // bits held back so a flag's leading part never reaches the octet stage
    localparam int HOLD_BITS = FLAG_RUN + 1;

    localparam logic [15:0] POLY16 = 16'h8408;
    localparam logic [15:0] RES16  = 16'hF0B8;
    localparam logic [31:0] POLY32 = 32'hEDB88320;
    localparam logic [31:0] RES32  = 32'hDEBB20E3;

    typedef enum logic [1:0] {
        ST_GOOD    = 2'b00,
        ST_CRC_ERR = 2'b01,
        ST_ABORT   = 2'b10
    } frm_stat_e;

endpackage

// File: rtl/hdlc_rx_deframe.sv
module hdlc_rx_deframe
    import hdlc_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic bit_in,
    output logic dbit_vld,
    output logic dbit,
    output logic flag_ev,
    output logic abort_ev
);

    typedef struct packed {
        logic [ONES_W-1:0]    ones;
        logic [HOLD_BITS-1:0] win;
        logic [HOLD_BITS-1:0] wvld;
        logic                 dv;
        logic                 db;
        logic                 fl;
        logic                 ab;
    } dfr_s;

    dfr_s q, d;

    always_comb begin
        d    = q;
        d.dv = 1'b0;
        d.fl = 1'b0;
        d.ab = 1'b0;
        if (bit_en) begin
            if (bit_in) begin
                if (q.ones == ONES_W'(FLAG_RUN)) begin
                    d.ab   = 1'b1;
                    d.wvld = '0;
                    d.ones = ONES_W'(ABORT_RUN);
                end else if (q.ones != ONES_W'(ABORT_RUN)) begin
                    d.dv   = q.wvld[HOLD_BITS-1];
                    d.db   = q.win[HOLD_BITS-1];
                    d.win  = {q.win[HOLD_BITS-2:0], 1'b1};
                    d.wvld = {q.wvld[HOLD_BITS-2:0], 1'b1};
                    d.ones = q.ones + ONES_W'(1);
                end
            end else begin
                if (q.ones == ONES_W'(STUFF_RUN)) begin
                    d.ones = '0;
                end else if (q.ones == ONES_W'(FLAG_RUN)) begin
                    d.fl   = 1'b1;
                    d.wvld = '0;
                    d.ones = '0;
                end else begin
                    d.dv   = q.wvld[HOLD_BITS-1];
                    d.db   = q.win[HOLD_BITS-1];
                    d.win  = {q.win[HOLD_BITS-2:0], 1'b0};
                    d.wvld = {q.wvld[HOLD_BITS-2:0], 1'b1};
                    d.ones = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign dbit_vld = q.dv;
    assign dbit     = q.db;
    assign flag_ev  = q.fl;
    assign abort_ev = q.ab;

    AST_DATA_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        dbit_vld |-> $past(bit_en)); // R11
    AST_FLAG_ENDS_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        flag_ev |-> ($past(bit_en) && !$past(bit_in))); // R10
    AST_ABORT_ENDS_ON_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_ev |-> ($past(bit_en) && $past(bit_in))); // R7

endmodule

// File: rtl/hdlc_rx_fcs.sv
module hdlc_rx_fcs
    import hdlc_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic dbit_vld,
    input  logic dbit,
    input  logic fcs32_sel,
    output logic crc_ok
);

    typedef struct packed {
        logic [15:0] c16;
        logic [31:0] c32;
    } fcs_s;

    fcs_s q, d;

    always_comb begin
        d = q;
        if (restart) begin
            d.c16 = '1;
            d.c32 = '1;
        end else if (dbit_vld) begin
            d.c16 = (q.c16 >> 1) ^ ((q.c16[0] ^ dbit) ? POLY16 : 16'h0);
            d.c32 = (q.c32 >> 1) ^ ((q.c32[0] ^ dbit) ? POLY32 : 32'h0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '1;
        end else begin
            q <= d;
        end
    end

    assign crc_ok = fcs32_sel ? (q.c32 == RES32) : (q.c16 == RES16);

endmodule

// File: rtl/hdlc_rx_octet.sv
module hdlc_rx_octet
    import hdlc_rx_pkg::*;
#(
    parameter int FCS_SHORT_BYTES = 2,
    parameter int FCS_LONG_BYTES  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dbit_vld,
    input  logic       dbit,
    input  logic       flag_ev,
    input  logic       abort_ev,
    input  logic       fcs32_sel,
    input  logic       crc_ok,
    output logic       out_vld,
    output logic [7:0] out_data,
    output logic       out_sof,
    output logic       out_eof,
    output frm_stat_e  out_stat
);

    localparam int LINE_DEPTH = FCS_LONG_BYTES + 1;
    localparam int CNT_W      = $clog2(LINE_DEPTH + 1);

    typedef struct packed {
        logic                       open;
        logic [7:0]                 sh;
        logic [2:0]                 nbit;
        logic [CNT_W-1:0]           cnt;
        logic [LINE_DEPTH-1:0][7:0] line;
        logic                       sof_pend;
        logic                       vld;
        logic [7:0]                 data;
        logic                       sof;
        logic                       eof;
        frm_stat_e                  stat;
    } oct_s;

    oct_s q, d;

    logic [CNT_W-1:0] fcsb;
    logic             full;
    logic [7:0]       oldest;
    logic [7:0]       newbyte;

    always_comb begin
        fcsb    = fcs32_sel ? CNT_W'(FCS_LONG_BYTES) : CNT_W'(FCS_SHORT_BYTES);
        full    = (q.cnt > fcsb);
        newbyte = {dbit, q.sh[7:1]};
        oldest  = q.line[0];
        for (int i = 0; i < LINE_DEPTH; i++) begin
            if (CNT_W'(i) == fcsb) begin
                oldest = q.line[i];
            end
        end

        d      = q;
        d.vld  = 1'b0;
        d.sof  = 1'b0;
        d.eof  = 1'b0;
        d.stat = ST_GOOD;

        if (flag_ev) begin
            if (q.open && full) begin
                d.vld  = 1'b1;
                d.data = oldest;
                d.sof  = q.sof_pend;
                d.eof  = 1'b1;
                if (q.nbit != 3'd0) begin
                    d.stat = ST_ABORT;
                end else if (crc_ok) begin
                    d.stat = ST_GOOD;
                end else begin
                    d.stat = ST_CRC_ERR;
                end
            end
            d.open     = 1'b1;
            d.cnt      = '0;
            d.nbit     = '0;
            d.sh       = '0;
            d.sof_pend = 1'b1;
        end else if (abort_ev) begin
            if (q.open && full) begin
                d.vld  = 1'b1;
                d.data = oldest;
                d.sof  = q.sof_pend;
                d.eof  = 1'b1;
                d.stat = ST_ABORT;
            end
            d.open = 1'b0;
        end else if (dbit_vld && q.open) begin
            d.sh   = newbyte;
            d.nbit = q.nbit + 3'd1;
            if (q.nbit == 3'd7) begin
                if (full) begin
                    d.vld      = 1'b1;
                    d.data     = oldest;
                    d.sof      = q.sof_pend;
                    d.sof_pend = 1'b0;
                end
                d.line = {q.line[LINE_DEPTH-2:0], newbyte};
                if (q.cnt != CNT_W'(LINE_DEPTH)) begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign out_vld  = q.vld;
    assign out_data = q.data;
    assign out_sof  = q.sof;
    assign out_eof  = q.eof;
    assign out_stat = q.stat;

    AST_GOOD_NEEDS_RESIDUE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && out_eof && out_stat == ST_GOOD) |-> $past(crc_ok)); // R4
    AST_CRCERR_NEEDS_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && out_eof && out_stat == ST_CRC_ERR) |-> !$past(crc_ok)); // R6
    AST_EOF_AFTER_DELIMITER: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && out_eof) |-> ($past(flag_ev) || $past(abort_ev))); // R7

endmodule

// File: rtl/hdlc_rx.sv
module hdlc_rx
    import hdlc_rx_pkg::*;
#(
    parameter int FCS_SHORT_BYTES = 2,
    parameter int FCS_LONG_BYTES  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       bit_in,
    input  logic       fcs32_sel,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       rx_sof,
    output logic       rx_eof,
    output logic [1:0] rx_status
);

    logic      dbit_vld;
    logic      dbit;
    logic      flag_ev;
    logic      abort_ev;
    logic      crc_ok;
    frm_stat_e stat;

    hdlc_rx_deframe u_deframe (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .bit_in   (bit_in),
        .dbit_vld (dbit_vld),
        .dbit     (dbit),
        .flag_ev  (flag_ev),
        .abort_ev (abort_ev)
    );

    hdlc_rx_fcs u_fcs (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (flag_ev | abort_ev),
        .dbit_vld  (dbit_vld),
        .dbit      (dbit),
        .fcs32_sel (fcs32_sel),
        .crc_ok    (crc_ok)
    );

    hdlc_rx_octet #(
        .FCS_SHORT_BYTES (FCS_SHORT_BYTES),
        .FCS_LONG_BYTES  (FCS_LONG_BYTES)
    ) u_octet (
        .clk       (clk),
        .rst_n     (rst_n),
        .dbit_vld  (dbit_vld),
        .dbit      (dbit),
        .flag_ev   (flag_ev),
        .abort_ev  (abort_ev),
        .fcs32_sel (fcs32_sel),
        .crc_ok    (crc_ok),
        .out_vld   (rx_valid),
        .out_data  (rx_data),
        .out_sof   (rx_sof),
        .out_eof   (rx_eof),
        .out_stat  (stat)
    );

    assign rx_status = stat;

    AST_MARKERS_NEED_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_sof || rx_eof) |-> rx_valid); // R12
    AST_STATUS_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_eof) |-> (rx_status == 2'b00)); // R12
    AST_OUTPUT_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(bit_en, 2)); // R11

endmodule

// File: tb/hdlc_rx_tb.sv
`timescale 1ns/1ps
module hdlc_rx_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       bit_in = 1'b0;
    logic       fcs32_sel = 1'b0;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       rx_sof;
    logic       rx_eof;
    logic [1:0] rx_status;

    always #2.5 clk = ~clk;

    hdlc_rx u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .bit_in    (bit_in),
        .fcs32_sel (fcs32_sel),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_sof    (rx_sof),
        .rx_eof    (rx_eof),
        .rx_status (rx_status)
    );

    localparam logic [1:0] S_GOOD = 2'b00;
    localparam logic [1:0] S_CRC  = 2'b01;
    localparam logic [1:0] S_ABT  = 2'b10;

    int n_chk = 0;
    int n_fail = 0;
    int gap_pct = 10;
    int tx_ones = 0;
    int out_cnt = 0;
    int txn = 0;
    logic [7:0]  txb [0:63];
    logic [11:0] exp_q [$];
    string       tag_q [$];
    logic [11:0] got_w;
    logic [11:0] exp_w;
    string       tag_w;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            out_cnt++;
            got_w = {rx_status, rx_eof, rx_sof, rx_data};
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2", "unexpected octet", {20'h0, got_w}, 32'h0);
            end else begin
                exp_w = exp_q.pop_front();
                tag_w = tag_q.pop_front();
                chk(got_w == exp_w, tag_w, "octet {stat,eof,sof,data}",
                    {20'h0, got_w}, {20'h0, exp_w});
            end
        end
    end

    function automatic logic [31:0] fcs_calc(input int n, input bit wide);
        logic [15:0] c16 = 16'hFFFF;
        logic [31:0] c32 = 32'hFFFFFFFF;
        for (int i = 0; i < n; i++) begin
            for (int b = 0; b < 8; b++) begin
                c16 = (c16 >> 1) ^ ((c16[0] ^ txb[i][b]) ? 16'h8408 : 16'h0);
                c32 = (c32 >> 1) ^ ((c32[0] ^ txb[i][b]) ? 32'hEDB88320 : 32'h0);
            end
        end
        return wide ? ~c32 : {16'h0, ~c16};
    endfunction

    task automatic drive_bit(input logic b);
        bit_en = 1'b1;
        bit_in = b;
        @(negedge clk);
        while (int'($urandom_range(99)) < gap_pct) begin
            bit_en = 1'b0;
            bit_in = 1'($urandom_range(1));
            @(negedge clk);
        end
        bit_en = 1'b0;
    endtask

    task automatic send_data_bit(input logic b);
        drive_bit(b);
        if (b) begin
            tx_ones++;
            if (tx_ones == 5) begin
                drive_bit(1'b0);
                tx_ones = 0;
            end
        end else begin
            tx_ones = 0;
        end
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_data_bit(v[i]);
    endtask

    task automatic send_flag();
        drive_bit(1'b0);
        for (int i = 0; i < 6; i++) drive_bit(1'b1);
        drive_bit(1'b0);
        tx_ones = 0;
    endtask

    task automatic send_shared_flag();
        for (int i = 0; i < 6; i++) drive_bit(1'b1);
        drive_bit(1'b0);
        tx_ones = 0;
    endtask

    task automatic settle();
        bit_en = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic build(input int nd, input bit corrupt);
        int fb;
        logic [31:0] f;
        fb = fcs32_sel ? 4 : 2;
        f = fcs_calc(nd, fcs32_sel);
        for (int k = 0; k < fb; k++) txb[nd + k] = f[8*k +: 8];
        txn = nd + fb;
        if (corrupt && nd > 0) begin
            txb[$urandom_range(nd - 1)] ^= 8'(1 << $urandom_range(7));
        end
    endtask

    task automatic expect_frame(input logic [1:0] st, input string tag);
        int fb;
        int last;
        fb = fcs32_sel ? 4 : 2;
        if (txn >= fb + 1) begin
            last = txn - fb - 1;
            for (int i = 0; i <= last; i++) begin
                exp_q.push_back({(i == last) ? st : 2'b00, i == last, i == 0, txb[i]});
                tag_q.push_back(tag);
            end
        end
    endtask

    // kind: 0 good, 1 FCS error, 2 abort, 3 partial octet at close
    task automatic run_frame(input int kind, input int nd, input string tag);
        build(nd, kind == 1);
        case (kind)
            1: expect_frame(S_CRC, tag);
            2, 3: expect_frame(S_ABT, tag);
            default: expect_frame(S_GOOD, tag);
        endcase
        for (int i = 0; i < txn; i++) send_byte(txb[i]);
        if (kind == 2) begin
            send_byte(8'h00);
            for (int i = 0; i < 7; i++) drive_bit(1'b1);
            tx_ones = 0;
            send_byte(8'($urandom));
            send_byte(8'($urandom));
        end else if (kind == 3) begin
            send_data_bit(1'b1);
            send_data_bit(1'b0);
            send_data_bit(1'b1);
        end
        send_flag();
        settle();
        chk(exp_q.size() == 0, tag, "pending expected octets", exp_q.size(), 0);
    endtask

    task automatic fill_random(input int nd);
        for (int i = 0; i < nd; i++) txb[i] = 8'($urandom);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int kind;
        int nd;
        string tg;
        void'($urandom(32'h1DC0_5EED));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rx_valid && !rx_sof && !rx_eof, "R1", "outputs after reset",
            {29'h0, rx_valid, rx_sof, rx_eof}, 0);

        // R2: flags only, normal and sharing a zero
        send_flag();
        for (int i = 0; i < 10; i++) send_flag();
        for (int i = 0; i < 3; i++) send_shared_flag();
        settle();
        chk(out_cnt == 0, "R2", "octets from flag stream", out_cnt, 0);

        // R3: payload full of long one runs
        txb[0] = 8'hFF; txb[1] = 8'h7E; txb[2] = 8'h3E;
        txb[3] = 8'hF8; txb[4] = 8'hFC; txb[5] = 8'h1F;
        run_frame(0, 6, "R3");

        // R12: single payload octet
        fill_random(1);
        run_frame(0, 1, "R12");

        // R8: FCS only, nothing delivered
        run_frame(0, 0, "R8");
        chk(out_cnt == 7, "R8", "octet count after short frame", out_cnt, 7);

        fill_random(10);
        run_frame(0, 10, "R4");
        fill_random(6);
        run_frame(1, 6, "R6");
        fill_random(7);
        run_frame(2, 7, "R7");
        fill_random(5);
        run_frame(3, 5, "R9");

        // R10: back-to-back and shared-zero flags before the frame
        send_flag();
        send_shared_flag();
        fill_random(4);
        run_frame(0, 4, "R10");

        // R11: many disabled cycles with garbage on bit_in
        gap_pct = 60;
        fill_random(8);
        run_frame(0, 8, "R11");
        gap_pct = 10;

        fcs32_sel = 1'b1;
        settle();
        fill_random(9);
        run_frame(0, 9, "R5");
        run_frame(0, 0, "R8");
        fill_random(3);
        run_frame(1, 3, "R6");
        fill_random(6);
        run_frame(2, 6, "R7");
        fill_random(2);
        run_frame(3, 2, "R9");

        for (int it = 0; it < 60; it++) begin
            fcs32_sel = 1'($urandom_range(1));
            settle();
            kind = int'($urandom_range(9));
            kind = (kind < 5) ? 0 : (kind < 7) ? 1 : (kind < 9) ? 2 : 3;
            nd = int'($urandom_range(24));
            fill_random(nd);
            case (kind)
                1: tg = "R6";
                2: tg = "R7";
                3: tg = "R9";
                default: tg = fcs32_sel ? "R5" : "R4";
            endcase
            if ($urandom_range(3) == 0) send_shared_flag();
            run_frame(kind, nd, tg);
        end

        settle();
        chk(exp_q.size() == 0, "R4", "expected octets left at end", exp_q.size(), 0);
        finish_run();
    end

endmodule